// File: doc/BRIEF.md
# Page-Table Accessed/Dirty Flag Updater

After a two-level translation walk has finished, this block writes the accessed and dirty flags back into the directory entry and the table entry in memory. It receives the walk result as one pulse: both entry addresses, both entry values as the walker saw them, and whether the access that caused the walk was a write. It then runs read-modify-write transactions on a simple memory port and pulses `done` when every required flag is in place.

Two configuration inputs choose the write-back policy. The first picks the ordering. In step-by-step ordering, each entry is handled in full, directory first and table second. In batched ordering, all the reads go out, then all the writes, then all the checks. The second input enables a check read after each write. A failed check repeats the update. If an entry sits in memory that ignores writes, the repeats never end, and this is intended. A retry counter raises `hang_detected` once it passes a programmable limit. The loop keeps running after that.

The memory port carries one transaction at a time. A request is a single-cycle `mem_req` with address, write enable and write data. Every request, read or write, gets exactly one `mem_rsp_valid` cycle, which comes at least one cycle after the request.

Top module: `pt_ad_updater`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `mem_req` and `hang_detected` are all low.
- R2: The accessed flag is bit 5 (0x20) and the dirty flag is bit 6 (0x40) of a 32-bit entry. The directory entry needs only the accessed flag. The table entry needs the accessed flag, plus the dirty flag when `walk_write` is 1. An entry whose walk value already holds all of its required flags gets no memory transaction at all.
- R3: Each update reads the entry and then writes back the value read OR the required flags. If the value read already holds those flags, no write is issued for that entry.
- R4: With `cfg_deferred` = 0, the directory entry's whole sequence (read, write, and check read if enabled) finishes before the first request to the table entry.
- R5: With `cfg_deferred` = 1, each pass issues every needed read first (directory before table), then every needed write in the same order, then every check read in the same order.
- R6: With `cfg_verify` = 1, each write is followed by a read of the same address. If that read lacks a required flag, the update is repeated. In step-by-step mode the read-write-check of that entry is repeated. In batched mode a new pass covers only the failed entries. With `cfg_verify` = 0, a write completes the entry.
- R7: Each failed check read adds one to a retry count, which is cleared when a walk is accepted. `hang_detected` is high whenever that count is greater than `hang_limit`. The sequence keeps issuing transactions after `hang_detected` rises.
- R8: `done` is high for exactly one cycle. That cycle follows the cycle in which the last response is taken, or follows the accept cycle when no transaction is needed. `busy` is high from the cycle after acceptance up to and including the `done` cycle. A `walk_valid` pulse that arrives while `busy` is high is ignored.
- R9: `mem_req` is never high for two cycles in a row, and no new request is issued until the response to the previous one has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_valid | input | 1 | One-cycle pulse carrying a finished walk |
| dir_addr | input | 32 | Byte address of the directory entry |
| dir_val | input | 32 | Directory entry value seen by the walk |
| tbl_addr | input | 32 | Byte address of the table entry |
| tbl_val | input | 32 | Table entry value seen by the walk |
| walk_write | input | 1 | Access was a write (dirty flag required) |
| cfg_deferred | input | 1 | 0: step-by-step ordering, 1: batched ordering |
| cfg_verify | input | 1 | Enables the check read after each write |
| hang_limit | input | 16 | Retry count above which the hang status is raised |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response strobe for the outstanding request |
| mem_rdata | input | 32 | Read data returned with the response |
| busy | output | 1 | A walk update is in progress |
| done | output | 1 | One-cycle completion pulse |
| hang_detected | output | 1 | Retry count has passed the limit |

## Verification
Two functions can land on the same cycle. In the retry loop over write-ignoring memory, the failed check response that pushes the count past `hang_limit` is taken on the same edge that moves the sequencer back to re-issue its read. The bench provokes this by placing an entry in a read-only region with a small limit. At every cycle it compares `hang_detected` against its own count of failed check responses, and it still matches the request that follows against the modelled trace. In the same way, a stray `walk_valid` can coincide with a response in flight. The bench judges this through the request trace, which must stay unchanged, and through a count of exactly one `done`.

// File: rtl/ptad_pkg.sv
package ptad_pkg;
  localparam int unsigned ENTRY_W = 32;
  localparam int unsigned ACC_BIT = 5;
  localparam int unsigned DIRTY_BIT = 6;
  localparam int unsigned LEVELS = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ,
    S_WR_WAIT,
    S_VF_REQ,
    S_VF_WAIT,
    S_FIN
  } ptad_state_e;
endpackage

// File: rtl/ptad_need.sv
module ptad_need
  import ptad_pkg::*;
#(
  parameter int unsigned DW = ENTRY_W
) (
  input  logic [DW-1:0]     dir_val,
  input  logic [DW-1:0]     tbl_val,
  input  logic              is_wr,
  output logic [DW-1:0]     mask_dir,
  output logic [DW-1:0]     mask_tbl,
  output logic [LEVELS-1:0] need
);
  logic [DW-1:0] mask_lv [LEVELS];
  logic [DW-1:0] val_lv  [LEVELS];

  assign val_lv[0] = dir_val;
  assign val_lv[1] = tbl_val;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    // dirty flag only at the last level, and only for write accesses
    if (g == LEVELS - 1) begin : g_leaf
      assign mask_lv[g] = (DW'(1) << ACC_BIT) | (is_wr ? (DW'(1) << DIRTY_BIT) : '0);
    end else begin : g_dir
      assign mask_lv[g] = DW'(1) << ACC_BIT;
    end
    assign need[g] = (val_lv[g] & mask_lv[g]) != mask_lv[g];
  end

  assign mask_dir = mask_lv[0];
  assign mask_tbl = mask_lv[LEVELS-1];
endmodule

// File: rtl/ptad_retry_mon.sv
module ptad_retry_mon #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          hang
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (cnt_q != '1)    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hang = cnt_q > limit;

  // R7: accepting a walk clears the retry history
  a_r7_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R7: once raised, the status stays up while the loop runs on
  a_r7_hang_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hang && !clr && $stable(limit)) |=> hang);
endmodule

// File: rtl/ptad_seq.sv
module ptad_seq
  import ptad_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = ENTRY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     dir_addr,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [DW-1:0]     mask_dir,
  input  logic [DW-1:0]     mask_tbl,
  input  logic [LEVELS-1:0] need_in,
  input  logic              deferred,
  input  logic              verify,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic              vf_fail
);
  ptad_state_e     st_q, st_d;
  logic            idx_q, idx_d;
  logic [1:0]      need_q, need_d;
  logic [1:0]      wm_q, wm_d;
  logic [AW-1:0]   addr_q [LEVELS];
  logic [DW-1:0]   mask_q [LEVELS];
  logic [DW-1:0]   rdv_q  [LEVELS];
  logic            defer_q, verify_q;
  logic            rsp_ok, rd_cap, adv;
  logic [1:0]      upd;

  assign rsp_ok = (mem_rdata & mask_q[idx_q]) == mask_q[idx_q];
  assign rd_cap = (st_q == S_RD_WAIT) && mem_rsp_valid;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    need_d  = need_q;
    wm_d    = wm_q;
    accept  = 1'b0;
    vf_fail = 1'b0;
    adv     = 1'b0;
    upd     = '0;
    unique case (st_q)
      S_IDLE: if (start) begin
        accept = 1'b1;
        need_d = need_in;
        wm_d   = '0;
        idx_d  = ~need_in[0];
        st_d   = (need_in == '0) ? S_FIN : S_RD_REQ;
      end
      S_RD_REQ: st_d = S_RD_WAIT;
      S_RD_WAIT: if (mem_rsp_valid) begin
        if (!defer_q) begin
          if (rsp_ok) adv = 1'b1;
          else        st_d = S_WR_REQ;
        end else begin
          upd = wm_q;
          upd[idx_q] = ~rsp_ok;
          wm_d = upd;
          if (!idx_q && need_q[1]) begin
            idx_d = 1'b1;
            st_d  = S_RD_REQ;
          end else begin
            need_d = upd;
            idx_d  = ~upd[0];
            st_d   = (upd == '0) ? S_FIN : S_WR_REQ;
          end
        end
      end
      S_WR_REQ: st_d = S_WR_WAIT;
      S_WR_WAIT: if (mem_rsp_valid) begin
        if (!defer_q) begin
          if (verify_q) st_d = S_VF_REQ;
          else          adv  = 1'b1;
        end else if (!idx_q && wm_q[1]) begin
          idx_d = 1'b1;
          st_d  = S_WR_REQ;
        end else if (verify_q) begin
          idx_d = ~wm_q[0];
          st_d  = S_VF_REQ;
        end else begin
          need_d = '0;
          st_d   = S_FIN;
        end
      end
      S_VF_REQ: st_d = S_VF_WAIT;
      S_VF_WAIT: if (mem_rsp_valid) begin
        vf_fail = ~rsp_ok;
        if (!defer_q) begin
          if (rsp_ok) adv  = 1'b1;
          else        st_d = S_RD_REQ;
        end else begin
          upd = need_q;
          upd[idx_q] = ~rsp_ok;
          need_d = upd;
          if (!idx_q && wm_q[1]) begin
            idx_d = 1'b1;
            st_d  = S_VF_REQ;
          end else begin
            wm_d  = '0;
            idx_d = ~upd[0];
            st_d  = (upd == '0) ? S_FIN : S_RD_REQ;
          end
        end
      end
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      need_d[idx_q] = 1'b0;
      if (!idx_q && need_q[1]) begin
        idx_d = 1'b1;
        st_d  = S_RD_REQ;
      end else begin
        st_d = S_FIN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= 1'b0;
      need_q <= '0;
      wm_q   <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      need_q <= need_d;
      wm_q   <= wm_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q[0] <= dir_addr;
      addr_q[1] <= tbl_addr;
      mask_q[0] <= mask_dir;
      mask_q[1] <= mask_tbl;
      defer_q   <= deferred;
      verify_q  <= verify;
    end
    if (rd_cap) rdv_q[idx_q] <= mem_rdata;
  end

  assign mem_req   = (st_q == S_RD_REQ) || (st_q == S_WR_REQ) || (st_q == S_VF_REQ);
  assign mem_we    = (st_q == S_WR_REQ);
  assign mem_addr  = addr_q[idx_q];
  assign mem_wdata = rdv_q[idx_q] | mask_q[idx_q];
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);

  // history of the previous request, kept only for the checks below
  logic          last_we_q;
  logic [AW-1:0] last_addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_we_q   <= 1'b0;
      last_addr_q <= '0;
    end else if (mem_req) begin
      last_we_q   <= mem_we;
      last_addr_q <= mem_addr;
    end
  end

  a_r9_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_no_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R3: a step-by-step write always targets the entry just read
  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !defer_q) |-> (!last_we_q && last_addr_q == mem_addr));
  // R6: with checking on, the read after a step-by-step write hits the same entry
  a_r6_check_same_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && last_we_q && verify_q && !defer_q) |-> (mem_addr == last_addr_q));
endmodule

// File: rtl/pt_ad_updater.sv
module pt_ad_updater
  import ptad_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = ENTRY_W,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          walk_valid,
  input  logic [AW-1:0] dir_addr,
  input  logic [DW-1:0] dir_val,
  input  logic [AW-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_val,
  input  logic          walk_write,
  input  logic          cfg_deferred,
  input  logic          cfg_verify,
  input  logic [CW-1:0] hang_limit,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          hang_detected
);
  logic [DW-1:0]     mask_dir, mask_tbl;
  logic [LEVELS-1:0] need;
  logic              accept, vf_fail;

  ptad_need #(.DW(DW)) u_need (
    .dir_val (dir_val),
    .tbl_val (tbl_val),
    .is_wr   (walk_write),
    .mask_dir(mask_dir),
    .mask_tbl(mask_tbl),
    .need    (need)
  );

  ptad_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (walk_valid),
    .dir_addr     (dir_addr),
    .tbl_addr     (tbl_addr),
    .mask_dir     (mask_dir),
    .mask_tbl     (mask_tbl),
    .need_in      (need),
    .deferred     (cfg_deferred),
    .verify       (cfg_verify),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rdata    (mem_rdata),
    .busy         (busy),
    .done         (done),
    .accept       (accept),
    .vf_fail      (vf_fail)
  );

  ptad_retry_mon #(.CW(CW)) u_mon (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .inc  (vf_fail),
    .limit(hang_limit),
    .hang (hang_detected)
  );
endmodule

// File: tb/pt_ad_updater_test.sv
module pt_ad_updater_test;
  localparam logic [31:0] ACC = 32'h20;
  localparam logic [31:0] DRT = 32'h40;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, walk_valid, walk_write, cfg_deferred, cfg_verify;
  logic [31:0] dir_addr, dir_val, tbl_addr, tbl_val;
  logic [15:0] hang_limit;
  logic        mem_req, mem_we, mem_rsp_valid, busy, done, hang_detected;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  pt_ad_updater uut (
    .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid),
    .dir_addr(dir_addr), .dir_val(dir_val), .tbl_addr(tbl_addr), .tbl_val(tbl_val),
    .walk_write(walk_write), .cfg_deferred(cfg_deferred), .cfg_verify(cfg_verify),
    .hang_limit(hang_limit), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .hang_detected(hang_detected)
  );

  typedef struct packed {
    logic        we;
    logic        chk;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] mask;
  } txn_t;

  txn_t        exq[$];
  logic [31:0] bmem [16];
  int          total = 0, bad = 0;
  int          cyc = 0, pend = 0, lat = 1, fails = 0, lim_cur = 0;
  int          done_cnt = 0, done_cyc = 0, last_rsp_cyc = 0, seen = 0;
  logic        pend_chk;
  logic [31:0] pend_data, pend_mask;
  string       cur_tag = "R1";
  bit          finished = 0;

  function automatic bit in_rom(logic [31:0] a);
    return a[5:2] >= 4'd12;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(logic we, logic c, logic [31:0] a, logic [31:0] d, logic [31:0] m);
    txn_t t;
    t.we = we; t.chk = c; t.addr = a; t.data = d; t.mask = m;
    exq.push_back(t);
  endtask

  // behavioural expectation of the request trace, from the requirements
  task automatic build_exp(logic [31:0] da, dv, ta, tv, bit wr, dfr, vf, int cap);
    logic [31:0] mm [16];
    logic [31:0] ad [2];
    logic [31:0] mk [2];
    logic [31:0] rv [2];
    logic [31:0] v;
    bit nd [2];
    bit wm [2];
    bit fl [2];
    bit go;
    mm = bmem;
    ad[0] = da; ad[1] = ta;
    mk[0] = ACC; mk[1] = ACC | (wr ? DRT : 32'h0);
    nd[0] = (dv & mk[0]) != mk[0];
    nd[1] = (tv & mk[1]) != mk[1];
    exq.delete();
    if (!dfr) begin
      for (int e = 0; e < 2; e++) begin
        go = nd[e];
        while (go && exq.size() < cap) begin
          rv[e] = mm[ad[e][5:2]];
          push(0, 0, ad[e], 32'h0, mk[e]);
          if ((rv[e] & mk[e]) == mk[e]) go = 0;
          else begin
            push(1, 0, ad[e], rv[e] | mk[e], mk[e]);
            if (!in_rom(ad[e])) mm[ad[e][5:2]] = rv[e] | mk[e];
            if (!vf) go = 0;
            else begin
              v = mm[ad[e][5:2]];
              push(0, 1, ad[e], 32'h0, mk[e]);
              if ((v & mk[e]) == mk[e]) go = 0;
            end
          end
        end
      end
    end else begin
      go = nd[0] | nd[1];
      while (go && exq.size() < cap) begin
        for (int e = 0; e < 2; e++) begin
          wm[e] = 0;
          if (nd[e]) begin
            rv[e] = mm[ad[e][5:2]];
            push(0, 0, ad[e], 32'h0, mk[e]);
            wm[e] = (rv[e] & mk[e]) != mk[e];
          end
        end
        for (int e = 0; e < 2; e++) if (wm[e]) begin
          push(1, 0, ad[e], rv[e] | mk[e], mk[e]);
          if (!in_rom(ad[e])) mm[ad[e][5:2]] = rv[e] | mk[e];
        end
        if (!vf) go = 0;
        else begin
          for (int e = 0; e < 2; e++) begin
            fl[e] = 0;
            if (wm[e]) begin
              v = mm[ad[e][5:2]];
              push(0, 1, ad[e], 32'h0, mk[e]);
              fl[e] = (v & mk[e]) != mk[e];
            end
          end
          nd = fl;
          go = fl[0] | fl[1];
        end
      end
    end
  endtask

  // memory model and per-cycle comparison
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) chk(hang_detected == (fails > lim_cur), "R7 hang status", 32'(hang_detected), 32'(fails > lim_cur));
      if (done) begin done_cnt++; done_cyc = cyc; end
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rdata = pend_data;
          last_rsp_cyc = cyc;
          if (pend_chk && ((pend_data & pend_mask) != pend_mask)) fails++;
        end
      end
      if (mem_req && rst_n) begin
        txn_t t;
        seen++;
        if (exq.size() == 0) chk(0, {cur_tag, " R9 unexpected request"}, mem_addr, 32'h0);
        else begin
          t = exq.pop_front();
          chk(mem_we == t.we, {cur_tag, " R3 request kind"}, 32'(mem_we), 32'(t.we));
          chk(mem_addr == t.addr, {cur_tag, " R4 R5 request order"}, mem_addr, t.addr);
          if (t.we) chk(mem_wdata == t.data, {cur_tag, " R2 write data"}, mem_wdata, t.data);
          pend_chk = t.chk;
          pend_mask = t.mask;
        end
        if (mem_we && !in_rom(mem_addr)) bmem[mem_addr[5:2]] = mem_wdata;
        pend_data = bmem[mem_addr[5:2]];
        pend = lat;
        lat = (lat == 1) ? 2 : 1;
      end
    end
  end

  task automatic init_mem();
    for (int i = 0; i < 16; i++) bmem[i] = 32'h0000_1007 + (i << 12);
  endtask

  task automatic do_reset(int lim);
    @(negedge clk); #1;
    rst_n = 1'b0;
    walk_valid = 1'b0;
    pend = 0; fails = 0; done_cnt = 0; seen = 0; lim_cur = lim;
    hang_limit = 16'(lim);
    exq.delete();
    repeat (2) @(negedge clk);
    #1;
    chk(!busy && !done && !mem_req && !hang_detected, "R1 reset outputs",
        {28'h0, busy, done, mem_req, hang_detected}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !done && !mem_req && !hang_detected, "R1 after release",
        {28'h0, busy, done, mem_req, hang_detected}, 32'h0);
  endtask

  task automatic run(string tag, logic [31:0] da, dv, ta, tv, bit wr, dfr, vf,
                     int lim, bit ends, bit extra);
    int s, n_exp;
    cur_tag = tag;
    do_reset(lim);
    build_exp(da, dv, ta, tv, wr, dfr, vf, ends ? 200 : 40);
    n_exp = exq.size();
    dir_addr = da; dir_val = dv; tbl_addr = ta; tbl_val = tv;
    walk_write = wr; cfg_deferred = dfr; cfg_verify = vf;
    walk_valid = 1'b1;
    s = cyc;
    @(negedge clk); #1;
    walk_valid = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk);
      #1;
      dir_addr = 32'h0; tbl_addr = 32'h4; dir_val = 32'h0; tbl_val = 32'h0;
      walk_valid = 1'b1;
      @(negedge clk); #1;
      walk_valid = 1'b0;
    end
    if (ends) begin
      for (int w = 0; w < 600 && done_cnt == 0; w++) @(negedge clk);
      repeat (4) @(negedge clk);
      #1;
      chk(done_cnt == 1, {tag, " R8 single done"}, 32'(done_cnt), 32'd1);
      chk(exq.size() == 0, {tag, " R9 trace complete"}, 32'(exq.size()), 32'd0);
      chk(seen == n_exp, {tag, " R3 request count"}, 32'(seen), 32'(n_exp));
      chk(done_cyc == ((n_exp == 0) ? s + 1 : last_rsp_cyc + 1), {tag, " R8 done timing"},
          32'(done_cyc), 32'((n_exp == 0) ? s + 1 : last_rsp_cyc + 1));
      chk(!busy, {tag, " R8 idle after done"}, 32'(busy), 32'd0);
    end else begin
      for (int w = 0; w < 600 && seen < 30; w++) @(negedge clk);
      #1;
      chk(seen >= 30, {tag, " R6 retry loop continues"}, 32'(seen), 32'd30);
      chk(hang_detected, {tag, " R7 hang raised"}, 32'(hang_detected), 32'd1);
      chk(busy && done_cnt == 0, {tag, " R7 loop not aborted"}, 32'(done_cnt), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; walk_valid = 1'b0; walk_write = 1'b0; cfg_deferred = 1'b0; cfg_verify = 1'b0;
    dir_addr = '0; dir_val = '0; tbl_addr = '0; tbl_val = '0; hang_limit = '0;
    init_mem();
    // R4 R2: step-by-step, read access, dirty must stay clear
    run("R4", 32'h10, 32'h1001, 32'h24, 32'h2001, 0, 0, 0, 100, 1, 0);
    init_mem();
    // R6: step-by-step write access with check reads
    run("R6", 32'h10, 32'h1001, 32'h24, 32'h2001, 1, 0, 1, 100, 1, 0);
    init_mem();
    // R2: all flags already present in the walk values
    run("R2", 32'h10, 32'h1021, 32'h24, 32'h2061, 1, 0, 1, 100, 1, 0);
    init_mem();
    // R2: only the dirty flag missing on the table entry
    run("R2", 32'h10, 32'h1021, 32'h24, 32'h2021, 1, 0, 1, 100, 1, 0);
    init_mem();
    bmem[4] = bmem[4] | ACC;
    // R3: memory already holds the flag that the walk value lacked
    run("R3", 32'h10, 32'h1001, 32'h24, 32'h2021, 0, 0, 0, 100, 1, 0);
    init_mem();
    // R5: batched ordering with check reads
    run("R5", 32'h10, 32'h1001, 32'h24, 32'h2001, 1, 1, 1, 100, 1, 0);
    init_mem();
    // R8: batched, no check reads, stray walk pulse while busy
    run("R8", 32'h18, 32'h0, 32'h2c, 32'h0, 1, 1, 0, 100, 1, 1);
    init_mem();
    // R8: step-by-step with stray walk pulse while busy
    run("R8", 32'h10, 32'h0, 32'h24, 32'h0, 1, 0, 1, 100, 1, 1);
    init_mem();
    // R7: table entry in write-ignoring memory, step-by-step, small limit
    run("R7", 32'h10, 32'h1001, 32'h34, 32'h2001, 1, 0, 1, 3, 0, 0);
    init_mem();
    // R7: directory entry in write-ignoring memory, batched
    run("R7", 32'h38, 32'h1001, 32'h24, 32'h2001, 0, 1, 1, 5, 0, 0);
    init_mem();
    // R6: write-ignoring memory without check reads still completes
    run("R6", 32'h10, 32'h1001, 32'h34, 32'h2001, 1, 0, 0, 0, 1, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule